// File: doc/BRIEF.md
# Virtual Channel Buffer Allocator

This block hands out receive data buffers to three virtual channels that share one pool of eight buffers. The three channels are response (index 0), non-posted request (index 1) and posted request (index 2). Each time the allocator decides that a channel may take one more buffer, it pulses that channel's release strobe. That strobe is the cue to return one credit to the far end of the link. The block keeps a per-channel count of buffers that are released and still held: credits not yet used plus buffers that hold a packet.

Two numbers govern each channel, and both are programmed as the count minus one in a 2-bit field. The floor is the number of buffers the channel is guaranteed. The ceiling is the number the allocator tries to keep released and held for the channel. Buffers above the sum of the floors form a shared pool. Channels that are at or above their floor take from that pool, up to their ceiling. A channel below its floor always wins over a channel taking from the pool. Among equals, one release is granted per cycle in round-robin order.

The consumer reports two kinds of event for each channel. A consume event means a received packet now occupies a released buffer. A free event means a buffer has been drained and returns to the pool. The configuration word is expected to stay stable while reset is low.

Top module: `vc_buf_alloc`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, every release strobe is 0 and every allocation count is 0. The first grant after reset goes to channel 0.
- R2: The configuration word is decoded as follows. Floor fields sit at bits 1:0, 3:2 and 5:4, and ceiling fields sit at bits 9:8, 11:10 and 13:12, for channels 0, 1 and 2 in that order. A field value v means v+1 buffers. Bits 7:6 and 15:14 have no effect.
- R3: At most one release strobe is high in any cycle. A release happens only when the total of all allocation counts is below 8 and the channel's count is below its effective ceiling. The total never exceeds 8.
- R4: An allocation count rises by 1 at the same clock edge that raises its release strobe. It falls by 1 at the edge that samples an accepted free event. A consume event leaves the count unchanged.
- R5: When any channel below its floor is eligible, only channels below their floor may be granted.
- R6: Among the competing channels, the grant goes to the first one found after the most recently granted channel, searching in the order 0, 1, 2 and wrapping around.
- R7: A consume event on a channel with no unused credit has no effect. A free event on a channel with no occupied buffer has no effect.
- R8: The effective ceiling is the larger of the ceiling and the floor. A ceiling programmed below the floor therefore does not stop a channel from reaching its floor.
- R9: The release strobe is registered. A buffer freed at edge N can be released again to the same channel no earlier than edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | 16 | Floor and ceiling fields, each holding a count minus one |
| consume_i | input | 3 | Per-channel pulse: a packet occupied a released buffer |
| free_i | input | 3 | Per-channel pulse: a buffer was drained and returned to the pool |
| release_o | output | 3 | Per-channel one-cycle strobe granting one more credit |
| alloc_o | output | 12 | Per-channel count of released plus occupied buffers, 4 bits each, channel 0 in the low bits |

## Verification
Outputs come from registers, so every event shows up at the ports exactly one edge after the cycle in which it is driven. A free event lowers the count at that first edge, and any release it enables appears one edge later. The driver drives each event just after a rising edge and queues the output values it expects for the following edge, tagged with that edge's cycle number. The monitor compares them at the falling edge of that same cycle. The monitor also checks the cap on the total and the one-strobe limit on every cycle out of reset.

// File: rtl/vcba_pkg.sv
package vcba_pkg;

    localparam int NUM_VC    = 3;
    localparam int NUM_BUF   = 8;
    localparam int FIELD_W   = 2;
    localparam int CFG_W     = 16;
    localparam int FLOOR_LSB = 0;
    localparam int CEIL_LSB  = 8;
    localparam int CNT_W     = $clog2(NUM_BUF + 1);
    localparam int SUM_W     = CNT_W + $clog2(NUM_VC);

    typedef enum logic [1:0] {
        VC_RESP  = 2'd0,
        VC_NPREQ = 2'd1,
        VC_PREQ  = 2'd2
    } vc_id_e;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t floor_n;
        cnt_t ceil_n;
    } vc_limit_t;

    function automatic cnt_t field_count(input logic [FIELD_W-1:0] f);
        return cnt_t'(f) + cnt_t'(1);
    endfunction

    function automatic cnt_t cnt_max(input cnt_t a, input cnt_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vcba_cfg_decode.sv
module vcba_cfg_decode
    import vcba_pkg::*;
#(
    parameter int N_VC = NUM_VC
) (
    input  logic [CFG_W-1:0] cfg_i,
    output vc_limit_t        lim_o [N_VC]
);

    for (genvar c = 0; c < N_VC; c++) begin : g_field
        localparam int FL = FLOOR_LSB + c * FIELD_W;
        localparam int CL = CEIL_LSB + c * FIELD_W;
        cnt_t floor_c;
        cnt_t ceil_c;

        always_comb begin
            floor_c          = field_count(cfg_i[FL +: FIELD_W]);
            ceil_c           = field_count(cfg_i[CL +: FIELD_W]);
            lim_o[c].floor_n = floor_c;
            lim_o[c].ceil_n  = cnt_max(ceil_c, floor_c);
        end
    end

endmodule

// File: rtl/vcba_chan_ctr.sv
module vcba_chan_ctr
    import vcba_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic grant_i,
    input  logic consume_i,
    input  logic free_i,
    output cnt_t alloc_o
);

    cnt_t credit_q;
    cnt_t held_q;
    logic take_ok;
    logic drain_ok;

    always_comb begin
        take_ok  = consume_i && (credit_q != '0);
        drain_ok = free_i && (held_q != '0);
        alloc_o  = credit_q + held_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            credit_q <= '0;
            held_q   <= '0;
        end else begin
            credit_q <= credit_q + cnt_t'(grant_i) - cnt_t'(take_ok);
            held_q   <= held_q + cnt_t'(take_ok) - cnt_t'(drain_ok);
        end
    end

    p_grant_adds_one_r4: assert property (@(posedge clk) disable iff (rst)
        (grant_i && !drain_ok) |=> alloc_o == $past(alloc_o) + cnt_t'(1));

    p_consume_keeps_count_r4: assert property (@(posedge clk) disable iff (rst)
        (consume_i && !grant_i && !free_i) |=> $stable(alloc_o));

    p_empty_free_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (free_i && held_q == '0 && !grant_i) |=> $stable(alloc_o));

endmodule

// File: rtl/vcba_rr_arb.sv
module vcba_rr_arb
    import vcba_pkg::*;
#(
    parameter int N = NUM_VC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] elig_i,
    input  logic [N-1:0] urgent_i,
    output logic [N-1:0] grant_o
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] win_idx;
    logic [N-1:0]     pool;
    logic             found;

    always_comb begin
        pool    = ((elig_i & urgent_i) != '0) ? (elig_i & urgent_i) : elig_i;
        grant_o = '0;
        found   = 1'b0;
        win_idx = last_q;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = int'(last_q) + k;
            if (idx >= N) idx = idx - N;
            if (!found && pool[idx]) begin
                found        = 1'b1;
                grant_o[idx] = 1'b1;
                win_idx      = IDX_W'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= IDX_W'(N - 1);
        end else if (found) begin
            last_q <= win_idx;
        end
    end

    p_single_grant_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    p_grant_only_eligible_r3: assert property (@(posedge clk) disable iff (rst)
        (grant_o & ~elig_i) == '0);

    p_floor_first_r5: assert property (@(posedge clk) disable iff (rst)
        ((elig_i & urgent_i) != '0) |-> ((grant_o & ~urgent_i) == '0));

endmodule

// File: rtl/vc_buf_alloc.sv
module vc_buf_alloc
    import vcba_pkg::*;
#(
    parameter int N_VC  = NUM_VC,
    parameter int N_BUF = NUM_BUF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CFG_W-1:0]      cfg_i,
    input  logic [N_VC-1:0]       consume_i,
    input  logic [N_VC-1:0]       free_i,
    output logic [N_VC-1:0]       release_o,
    output logic [N_VC*CNT_W-1:0] alloc_o
);

    vc_limit_t        lim [N_VC];
    cnt_t             alloc [N_VC];
    logic [N_VC-1:0]  grant;
    logic [N_VC-1:0]  elig;
    logic [N_VC-1:0]  urgent;
    logic [SUM_W-1:0] total;
    logic             room;
    logic [N_VC-1:0]  release_q;

    vcba_cfg_decode #(.N_VC(N_VC)) u_dec (
        .cfg_i (cfg_i),
        .lim_o (lim)
    );

    for (genvar c = 0; c < N_VC; c++) begin : g_chan
        vcba_chan_ctr u_ctr (
            .clk       (clk),
            .rst       (rst),
            .grant_i   (grant[c]),
            .consume_i (consume_i[c]),
            .free_i    (free_i[c]),
            .alloc_o   (alloc[c])
        );

        always_comb begin
            elig[c]   = room && (alloc[c] < lim[c].ceil_n);
            urgent[c] = alloc[c] < lim[c].floor_n;
        end

        assign alloc_o[c*CNT_W +: CNT_W] = alloc[c];
    end

    always_comb begin
        total = '0;
        for (int c = 0; c < N_VC; c++) begin
            total = total + SUM_W'(alloc[c]);
        end
        room = total < SUM_W'(N_BUF);
    end

    vcba_rr_arb #(.N(N_VC)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .elig_i   (elig),
        .urgent_i (urgent),
        .grant_o  (grant)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            release_q <= '0;
        end else begin
            release_q <= grant;
        end
    end

    assign release_o = release_q;

    p_pool_cap_r3: assert property (@(posedge clk) disable iff (rst)
        total <= SUM_W'(N_BUF));

    p_release_needs_room_r3: assert property (@(posedge clk) disable iff (rst)
        (release_o != '0) |-> ($past(total) < SUM_W'(N_BUF)));

    p_release_registered_r9: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |=> (release_o == $past(grant)));

endmodule

// File: tb/vc_buf_alloc_test.sv
module vc_buf_alloc_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg = 16'h1515;
    logic [2:0]  cons = '0;
    logic [2:0]  fre = '0;
    logic [2:0]  release_o;
    logic [11:0] alloc_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        int         cyc;
        logic [2:0] rel;
        int         a0;
        int         a1;
        int         a2;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    vc_buf_alloc uut (
        .clk       (clk),
        .rst       (rst),
        .cfg_i     (cfg),
        .consume_i (cons),
        .free_i    (fre),
        .release_o (release_o),
        .alloc_o   (alloc_o)
    );

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // monitor: compare queued expectations at the falling edge of their cycle
    initial forever begin
        @(negedge clk);
        while (sb.size() > 0 && sb[0].cyc == cyc) begin
            exp_t e;
            int g0, g1, g2;
            e  = sb.pop_front();
            g0 = int'(alloc_o[3:0]);
            g1 = int'(alloc_o[7:4]);
            g2 = int'(alloc_o[11:8]);
            checks++;
            if (release_o !== e.rel || g0 != e.a0 || g1 != e.a1 || g2 != e.a2) begin
                fails++;
                $display("FAIL %s cyc=%0d actual rel=%b alloc=%0d,%0d,%0d expected rel=%b alloc=%0d,%0d,%0d",
                         e.tag, cyc, release_o, g0, g1, g2, e.rel, e.a0, e.a1, e.a2);
            end
        end
        if (!rst) begin
            int sum;
            sum = int'(alloc_o[3:0]) + int'(alloc_o[7:4]) + int'(alloc_o[11:8]);
            checks++;
            if (sum > 8 || $countones(release_o) > 1) begin
                fails++;
                $display("FAIL R3 cyc=%0d actual total=%0d strobes=%b expected total<=8 and one strobe at most",
                         cyc, sum, release_o);
            end
        end
    end

    task automatic do_reset(input logic [15:0] c);
        rst = 1'b1;
        cfg = c;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst = 1'b0;
        sb.push_back('{cyc, 3'b000, 0, 0, 0, "R1 reset state"});
    endtask

    task automatic tick(input logic [2:0] c, input logic [2:0] f, input logic [2:0] r,
                        input int a0, input int a1, input int a2, input string tag);
        cons = c;
        fre  = f;
        sb.push_back('{cyc + 1, r, a0, a1, a2, tag});
        @(posedge clk); #1;
        cons = '0;
        fre  = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=run complete");
        finish_run();
    end

    initial begin
        // default fields: floor 2, ceiling 2 for each channel
        do_reset(16'h1515);
        tick(0, 0, 3'b001, 1, 0, 0, "R1 first grant ch0");
        tick(0, 0, 3'b010, 1, 1, 0, "R6 rr order");
        tick(0, 0, 3'b100, 1, 1, 1, "R6 rr order");
        tick(0, 0, 3'b001, 2, 1, 1, "R4 count rises with strobe");
        tick(0, 0, 3'b010, 2, 2, 1, "R6 rr order");
        tick(0, 0, 3'b100, 2, 2, 2, "R2 default fields");
        tick(0, 0, 3'b000, 2, 2, 2, "R3 ceiling stops release");
        tick(0, 3'b010, 3'b000, 2, 2, 2, "R7 free with nothing held");
        tick(0, 0, 3'b000, 2, 2, 2, "R7 free ignored");
        tick(3'b001, 0, 3'b000, 2, 2, 2, "R4 consume keeps count");
        tick(0, 3'b001, 3'b000, 1, 2, 2, "R4 free lowers count");
        tick(0, 0, 3'b001, 2, 2, 2, "R9 re-release one edge later");
        tick(3'b100, 0, 3'b000, 2, 2, 2, "R4 consume ch2");
        tick(3'b100, 0, 3'b000, 2, 2, 2, "R4 consume ch2");
        tick(3'b100, 0, 3'b000, 2, 2, 2, "R7 consume without credit");
        tick(0, 3'b100, 3'b000, 2, 2, 1, "R4 free ch2");
        tick(0, 3'b100, 3'b100, 2, 2, 1, "R4 free and release same edge");
        tick(0, 3'b100, 3'b100, 2, 2, 2, "R7 free with nothing held");
        tick(0, 0, 3'b000, 2, 2, 2, "R3 settled");

        // reserved bits set: must behave as default
        do_reset(16'hD5D5);
        tick(0, 0, 3'b001, 1, 0, 0, "R2 reserved ignored");
        tick(0, 0, 3'b010, 1, 1, 0, "R2 reserved ignored");
        tick(0, 0, 3'b100, 1, 1, 1, "R2 reserved ignored");
        tick(0, 0, 3'b001, 2, 1, 1, "R2 reserved ignored");
        tick(0, 0, 3'b010, 2, 2, 1, "R2 reserved ignored");
        tick(0, 0, 3'b100, 2, 2, 2, "R2 reserved ignored");
        tick(0, 0, 3'b000, 2, 2, 2, "R2 reserved ignored");

        // floor 1, ceiling 3 each: shared pool runs out
        do_reset(16'h2A00);
        tick(0, 0, 3'b001, 1, 0, 0, "R6 pool fill");
        tick(0, 0, 3'b010, 1, 1, 0, "R6 pool fill");
        tick(0, 0, 3'b100, 1, 1, 1, "R6 pool fill");
        tick(0, 0, 3'b001, 2, 1, 1, "R6 pool fill");
        tick(0, 0, 3'b010, 2, 2, 1, "R6 pool fill");
        tick(0, 0, 3'b100, 2, 2, 2, "R6 pool fill");
        tick(0, 0, 3'b001, 3, 2, 2, "R6 pool fill");
        tick(0, 0, 3'b010, 3, 3, 2, "R3 last buffer");
        tick(0, 0, 3'b000, 3, 3, 2, "R3 pool empty");
        tick(3'b001, 0, 3'b000, 3, 3, 2, "R4 consume ch0");
        tick(0, 3'b001, 3'b000, 2, 3, 2, "R4 free ch0");
        tick(0, 0, 3'b100, 2, 3, 3, "R6 rr skips to ch2");
        tick(0, 0, 3'b000, 2, 3, 3, "R3 pool empty");

        // ch0 floor 3, others floor 1, ceiling 3 each
        do_reset(16'h2A02);
        tick(0, 0, 3'b001, 1, 0, 0, "R5 floor fill");
        tick(0, 0, 3'b010, 1, 1, 0, "R5 floor fill");
        tick(0, 0, 3'b100, 1, 1, 1, "R5 floor fill");
        tick(0, 0, 3'b001, 2, 1, 1, "R5 only ch0 below floor");
        tick(0, 0, 3'b001, 3, 1, 1, "R5 only ch0 below floor");
        tick(0, 0, 3'b010, 3, 2, 1, "R6 pool after floors");
        tick(0, 0, 3'b100, 3, 2, 2, "R6 pool after floors");
        tick(0, 0, 3'b010, 3, 3, 2, "R6 wrap skips full ch0");
        tick(0, 0, 3'b000, 3, 3, 2, "R3 pool empty");
        tick(3'b011, 0, 3'b000, 3, 3, 2, "R4 consume two");
        tick(0, 3'b011, 3'b000, 2, 2, 2, "R4 free two");
        tick(0, 0, 3'b001, 3, 2, 2, "R5 below-floor ch0 first");
        tick(0, 0, 3'b010, 3, 3, 2, "R6 then rr");
        tick(0, 0, 3'b000, 3, 3, 2, "R3 pool empty");

        // ch0 floor 2 with ceiling 1: floor governs
        do_reset(16'h0001);
        tick(0, 0, 3'b001, 1, 0, 0, "R8 fill");
        tick(0, 0, 3'b010, 1, 1, 0, "R8 fill");
        tick(0, 0, 3'b100, 1, 1, 1, "R8 fill");
        tick(0, 0, 3'b001, 2, 1, 1, "R8 ceiling below floor");
        tick(0, 0, 3'b000, 2, 1, 1, "R8 stops at floor");

        repeat (3) @(posedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL scoreboard actual=%0d pending expected=0", sb.size());
        end
        finish_run();
    end

endmodule